// File: doc/BRIEF.md
# Legacy DMA Controller Control-Port Logic

This block holds the control side of a four-channel legacy DMA controller. A host side issues single-cycle write and read strobes with a 4-bit port index. Indices 8 to 15 select the control operations: command register, software request, single-channel mask, channel mode, byte-pointer clear, master clear, clear of all masks and load of all masks. Indices 0 to 7 belong to the address and count registers, which live elsewhere, so this block ignores them.

The block keeps an 8-bit status word. Its low nibble holds per-channel terminal-count flags and its high nibble holds per-channel request flags. It also keeps a 4-bit mask, an 8-bit command register and one 8-bit mode byte per channel. Peripheral request lines arrive as separate hold and release pulses for each channel. Transfer engines report terminal count through per-channel pulses. The block drives one run enable per channel that is unmasked and requesting, and it names the lowest-numbered such channel. It also drives a byte-pointer clear pulse, the command byte and all mode bytes, for use by the address/count half of the controller.

Top module: `dmac_ctrl`

## Requirements
- R1: After synchronous reset the mask is 1111, the status word is 0x00, the command byte is 0x00, every mode byte is 0x00 and every run enable is 0.
- R2: A write to index 8 loads the command byte only when (data AND 0xFB) equals 0. Any other value leaves the command byte unchanged. While command bit 2 is 1, every run enable is 0.
- R3: A write to index 9 selects channel data[1:0]. It sets status bit 4+ch to data[2] and clears status bit ch. For that channel it takes precedence over a request pulse in the same cycle.
- R4: A write to index 0xA sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. A write to index 0xE clears all mask bits. A write to index 0xF loads the mask from data[3:0].
- R5: A write to index 0xB stores the whole data byte as the mode of channel data[1:0]. The mode of channel ch appears on mode_bus[8ch+7:8ch].
- R6: ptr_clr is 1 in the cycle of a write to index 0xC or 0xD, and 0 in every other cycle.
- R7: A write to index 0xD clears the status word and the command byte and sets all four mask bits.
- R8: A read of index 8 returns the status word in the strobe cycle. At the next edge bits 3:0 clear and bits 7:4 keep their value, but a terminal-count pulse in the same cycle still sets its flag. A read of index 0xF returns {0000, mask}. Any other read index, or no read strobe, gives rdata 0x00.
- R9: A pulse on dreq_set[ch] sets status bit 4+ch and a pulse on dreq_clr[ch] clears it. When both pulse in the same cycle, the set wins.
- R10: A pulse on tc_hit[ch] sets status bit ch.
- R11: run_en[ch] is 1 exactly when mask bit ch is 0, status bit 4+ch is 1 and command bit 2 is 0. When any run enable is 1, next_vld is 1 and next_ch is the lowest such channel.
- R12: Writes to indices 0 to 7 change no state of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| idx | input | 4 | Port index of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| dreq_set | input | 4 | Per-channel request hold pulses |
| dreq_clr | input | 4 | Per-channel request release pulses |
| tc_hit | input | 4 | Per-channel terminal-count pulses |
| run_en | output | 4 | Per-channel run enables |
| next_vld | output | 1 | At least one channel may run |
| next_ch | output | 2 | Lowest channel that may run |
| ptr_clr | output | 1 | Byte-pointer clear pulse |
| cmd_out | output | 8 | Command byte |
| mode_bus | output | 32 | Mode bytes of all channels, channel 0 in the low byte |

## Verification
The hardest cases to reach are the same-cycle collisions on the status word. One is a status read meeting a terminal-count pulse, where the flag must not be lost to the read-clear. Another is a software request clear meeting a hardware request pulse on the same channel. A third is a request hold meeting a release. The stimulus drives both sources in the same cycle. It then reads the status back, or observes the run enables, in the following cycles. Reads of the status word change state, so the table-driven part observes the mask through the side-effect-free mask read instead.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the DMA controller control-port logic.
// Assumes the index field is 4 bits and control operations sit at 8..15.
package dmac_pkg;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IX_CMD     = 4'h8;
    localparam logic [IDX_W-1:0] IX_REQ     = 4'h9;
    localparam logic [IDX_W-1:0] IX_SMASK   = 4'hA;
    localparam logic [IDX_W-1:0] IX_MODE    = 4'hB;
    localparam logic [IDX_W-1:0] IX_CLRPTR  = 4'hC;
    localparam logic [IDX_W-1:0] IX_MCLR    = 4'hD;
    localparam logic [IDX_W-1:0] IX_CLRMASK = 4'hE;
    localparam logic [IDX_W-1:0] IX_WRMASK  = 4'hF;

    // Only the controller-disable bit may be set in an accepted command
    localparam logic [7:0] CMD_ALLOWED = 8'h04;
    localparam int         CMD_DIS_BIT = 2;
    // Bit that selects set versus clear in request and single-mask writes
    localparam int         SEL_BIT     = 2;

    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic clrptr;
        logic mclr;
        logic clrmask;
        logic wrmask;
    } wr_op_t;
endpackage

// File: rtl/dmac_decode.sv
// Index decoder: turns a write or read strobe plus index into one-hot
// operation strobes. Assumes at most one access per cycle per direction.
module dmac_decode
    import dmac_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    output wr_op_t           wop,
    output logic             rd_stat,
    output logic             rd_mask
);
    // Write decode; indices below 8 map to no operation
    always_comb begin
        wop = '0;
        if (wr_en) begin
            case (idx)
                IX_CMD:     wop.cmd     = 1'b1;
                IX_REQ:     wop.req     = 1'b1;
                IX_SMASK:   wop.smask   = 1'b1;
                IX_MODE:    wop.mode    = 1'b1;
                IX_CLRPTR:  wop.clrptr  = 1'b1;
                IX_MCLR:    wop.mclr    = 1'b1;
                IX_CLRMASK: wop.clrmask = 1'b1;
                IX_WRMASK:  wop.wrmask  = 1'b1;
                default:    wop = '0;
            endcase
        end
    end

    // Read decode for the two readable control indices
    always_comb begin
        rd_stat = rd_en && (idx == IX_CMD);
        rd_mask = rd_en && (idx == IX_WRMASK);
    end
endmodule

// File: rtl/dmac_status.sv
// Status word: low half terminal-count flags, high half request flags.
// Update order within one cycle: hardware request pulses (set beats
// release), then read-clear of the low half, then the software request
// write, then terminal-count pulses; master clear overrides all.
module dmac_status #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclr,
    input  logic             rd_clr,
    input  logic             req_wr,
    input  logic [CHW-1:0]   req_ch,
    input  logic             req_set,
    input  logic [NCH-1:0]   dreq_set,
    input  logic [NCH-1:0]   dreq_clr,
    input  logic [NCH-1:0]   tc_hit,
    output logic [2*NCH-1:0] status_q
);
    logic [NCH-1:0] hi_d, lo_d;

    // Next-state of both halves with the documented precedence
    always_comb begin
        hi_d = (status_q[2*NCH-1:NCH] & ~dreq_clr) | dreq_set;
        lo_d = status_q[NCH-1:0];
        if (rd_clr) lo_d = '0;
        if (req_wr) begin
            hi_d[req_ch] = req_set;
            lo_d[req_ch] = 1'b0;
        end
        lo_d = lo_d | tc_hit;
        if (mclr) begin
            hi_d = '0;
            lo_d = '0;
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= {hi_d, lo_d};
    end
endmodule

// File: rtl/dmac_mask.sv
// Channel mask register with single-bit, clear-all, load-all and master
// clear updates. Assumes the decoder presents at most one op per cycle.
module dmac_mask #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           clrmask,
    input  logic           wrmask,
    input  logic           smask,
    input  logic [CHW-1:0] sel_ch,
    input  logic           sel_set,
    input  logic [NCH-1:0] load_val,
    output logic [NCH-1:0] mask_q
);
    // Mask register; reset leaves every channel masked
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mclr)    mask_q <= '1;
        else if (clrmask) mask_q <= '0;
        else if (wrmask)  mask_q <= load_val;
        else if (smask)   mask_q[sel_ch] <= sel_set;
    end
endmodule

// File: rtl/dmac_pick.sv
// Fixed-priority pick: reports the lowest-numbered active request.
module dmac_pick #(
    parameter  int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           vld,
    output logic [CHW-1:0] ch
);
    // Scan from the top so the lowest active index is written last
    always_comb begin
        vld = |req;
        ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) ch = CHW'(i);
        end
    end
endmodule

// File: rtl/dmac_ctrl.sv
// Control-port half of a multi-channel DMA controller: command, mask,
// status and mode registers plus run-enable generation. Assumes
// single-cycle access strobes; indices below 8 belong to another block.
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int DW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    dreq_set,
    input  logic [NCH-1:0]    dreq_clr,
    input  logic [NCH-1:0]    tc_hit,
    output logic [NCH-1:0]    run_en,
    output logic              next_vld,
    output logic [CHW-1:0]    next_ch,
    output logic              ptr_clr,
    output logic [DW-1:0]     cmd_out,
    output logic [NCH*DW-1:0] mode_bus
);
    wr_op_t           wop;
    logic             rd_stat, rd_mask;
    logic [2*NCH-1:0] status_q;
    logic [NCH-1:0]   mask_q;
    logic [CHW-1:0]   wch;

    assign wch = wdata[CHW-1:0];

    dmac_decode u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .idx     (idx),
        .wop     (wop),
        .rd_stat (rd_stat),
        .rd_mask (rd_mask)
    );

    dmac_status #(.NCH(NCH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (wop.mclr),
        .rd_clr   (rd_stat),
        .req_wr   (wop.req),
        .req_ch   (wch),
        .req_set  (wdata[SEL_BIT]),
        .dreq_set (dreq_set),
        .dreq_clr (dreq_clr),
        .tc_hit   (tc_hit),
        .status_q (status_q)
    );

    dmac_mask #(.NCH(NCH)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (wop.mclr),
        .clrmask  (wop.clrmask),
        .wrmask   (wop.wrmask),
        .smask    (wop.smask),
        .sel_ch   (wch),
        .sel_set  (wdata[SEL_BIT]),
        .load_val (wdata[NCH-1:0]),
        .mask_q   (mask_q)
    );

    // Command register: rejects any write carrying unsupported bits
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_out <= '0;
        else if (wop.mclr) cmd_out <= '0;
        else if (wop.cmd && ((wdata & ~DW'(CMD_ALLOWED)) == '0)) cmd_out <= wdata;
    end

    // One mode byte per channel, written when the channel field matches
    for (genvar g = 0; g < NCH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)                             mode_bus[g*DW +: DW] <= '0;
            else if (wop.mode && (wch == CHW'(g)))  mode_bus[g*DW +: DW] <= wdata;
        end
    end

    // Run enables: unmasked, requesting, controller not disabled
    always_comb begin
        run_en = ~mask_q & status_q[2*NCH-1:NCH] & {NCH{~cmd_out[CMD_DIS_BIT]}};
    end

    dmac_pick #(.NCH(NCH)) u_pick (
        .req (run_en),
        .vld (next_vld),
        .ch  (next_ch)
    );

    // Byte-pointer clear pulse from its own index or master clear
    assign ptr_clr = wop.clrptr | wop.mclr;

    // Read data mux; zero when no readable index is strobed
    always_comb begin
        if (rd_stat)      rdata = DW'(status_q);
        else if (rd_mask) rdata = DW'(mask_q);
        else              rdata = '0;
    end
endmodule

// File: rtl/dmac_ctrl_chk.sv
// Property checker for dmac_ctrl, attached by bind below.
module dmac_ctrl_chk #(
    parameter  int NCH = 4,
    parameter  int DW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [3:0]       idx,
    input logic [DW-1:0]    wdata,
    input logic [NCH-1:0]   dreq_set,
    input logic [NCH-1:0]   tc_hit,
    input logic [2*NCH-1:0] status_q,
    input logic [NCH-1:0]   mask_q,
    input logic [DW-1:0]    cmd_out,
    input logic [NCH-1:0]   run_en,
    input logic             next_vld,
    input logic [CHW-1:0]   next_ch,
    input logic             ptr_clr
);
    assert_run_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en & mask_q) == '0);

    assert_run_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_out[2] |-> run_en == '0);

    assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 4'h8 && (wdata & ~DW'(8'h04)) != '0) |=> $stable(cmd_out));

    assert_mclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 4'hD) |=> (mask_q == '1 && status_q == '0 && cmd_out == '0));

    assert_rdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == 4'h8 && !wr_en && tc_hit == '0) |=> status_q[NCH-1:0] == '0);

    assert_dreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((status_q[2*NCH-1:NCH] & $past(dreq_set)) == $past(dreq_set)));

    assert_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == 4'hD) |=> ((status_q[NCH-1:0] & $past(tc_hit)) == $past(tc_hit)));

    assert_ptr_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (idx == 4'hC || idx == 4'hD)) |-> ptr_clr);

    assert_ptr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !ptr_clr);

    assert_pick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        next_vld |-> (run_en[next_ch] && (run_en & ~({NCH{1'b1}} << next_ch)) == '0));
endmodule

bind dmac_ctrl dmac_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .idx      (idx),
    .wdata    (wdata),
    .dreq_set (dreq_set),
    .tc_hit   (tc_hit),
    .status_q (status_q),
    .mask_q   (mask_q),
    .cmd_out  (cmd_out),
    .run_en   (run_en),
    .next_vld (next_vld),
    .next_ch  (next_ch),
    .ptr_clr  (ptr_clr)
);

// File: tb/sim_dmac_ctrl.sv
`timescale 1ns/1ps
module sim_dmac_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  dreq_set = '0, dreq_clr = '0, tc_hit = '0;
    logic [3:0]  run_en;
    logic        next_vld;
    logic [1:0]  next_ch;
    logic        ptr_clr;
    logic [7:0]  cmd_out;
    logic [31:0] mode_bus;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmac_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
        .wdata(wdata), .rdata(rdata), .dreq_set(dreq_set), .dreq_clr(dreq_clr),
        .tc_hit(tc_hit), .run_en(run_en), .next_vld(next_vld), .next_ch(next_ch),
        .ptr_clr(ptr_clr), .cmd_out(cmd_out), .mode_bus(mode_bus)
    );

    // Vector: wr, idx, data, dreq_set, dreq_clr | exp mask, exp cmd, exp run
    localparam int VN = 16;
    localparam logic [36:0] VEC [VN] = '{
        {1'b1, 4'hE, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 4'h0},  // R4 clear all
        {1'b0, 4'h0, 8'h00, 4'h5, 4'h0, 4'h0, 8'h00, 4'h5},  // R9 hold, R11
        {1'b1, 4'hA, 8'h04, 4'h0, 4'h0, 4'h1, 8'h00, 4'h4},  // R4 single set
        {1'b1, 4'h8, 8'h04, 4'h0, 4'h0, 4'h1, 8'h04, 4'h0},  // R2 disable
        {1'b1, 4'h8, 8'h01, 4'h0, 4'h0, 4'h1, 8'h04, 4'h0},  // R2 reject
        {1'b1, 4'h8, 8'h00, 4'h0, 4'h0, 4'h1, 8'h00, 4'h4},  // R2 zero accepted
        {1'b1, 4'hF, 8'h0C, 4'h0, 4'h0, 4'hC, 8'h00, 4'h1},  // R4 load all
        {1'b0, 4'h0, 8'h00, 4'h0, 4'h1, 4'hC, 8'h00, 4'h0},  // R9 release
        {1'b1, 4'h9, 8'h05, 4'h0, 4'h0, 4'hC, 8'h00, 4'h2},  // R3 soft set
        {1'b1, 4'h9, 8'h01, 4'h0, 4'h0, 4'hC, 8'h00, 4'h0},  // R3 soft clear
        {1'b1, 4'h3, 8'hFF, 4'h0, 4'h0, 4'hC, 8'h00, 4'h0},  // R12 low index
        {1'b1, 4'hD, 8'h00, 4'h0, 4'h0, 4'hF, 8'h00, 4'h0},  // R7 master clear
        {1'b1, 4'hE, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 4'h0},  // R7 status gone
        {1'b1, 4'h8, 8'h84, 4'h0, 4'h0, 4'h0, 8'h00, 4'h0},  // R2 reject
        {1'b1, 4'h9, 8'h02, 4'h4, 4'h0, 4'h0, 8'h00, 4'h0},  // R3 beats hold
        {1'b0, 4'h0, 8'h00, 4'h8, 4'h0, 4'h0, 8'h00, 4'h8}   // R9, R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; idx = '0; wdata = '0;
        dreq_set = '0; dreq_clr = '0; tc_hit = '0;
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk); idle(); wr_en = 1; idx = i; wdata = d;
        @(negedge clk); idle();
    endtask

    // Read in the current negedge slot; returns combinational rdata
    task automatic rd(input logic [3:0] i, output logic [7:0] v);
        @(negedge clk); idle(); rd_en = 1; idx = i;
        #1 v = rdata;
        @(negedge clk); idle();
    endtask

    initial begin
        logic [7:0] v;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk("R1 cmd", 32'(cmd_out), 32'h0);
        chk("R1 run", 32'(run_en), 32'h0);
        chk("R1 mode", mode_bus, 32'h0);
        rd(4'hF, v); chk("R1 mask", 32'(v), 32'h0F);
        rd(4'h8, v); chk("R1 status", 32'(v), 32'h00);

        // Table walk
        for (int k = 0; k < VN; k++) begin
            @(negedge clk); idle();
            wr_en = VEC[k][36]; idx = VEC[k][35:32]; wdata = VEC[k][31:24];
            dreq_set = VEC[k][23:20]; dreq_clr = VEC[k][19:16];
            @(negedge clk); idle(); rd_en = 1; idx = 4'hF;
            #1;
            chk($sformatf("vec%0d mask R4", k), 32'(rdata), 32'(VEC[k][15:12]));
            chk($sformatf("vec%0d cmd R2", k), 32'(cmd_out), 32'(VEC[k][11:4]));
            chk($sformatf("vec%0d run R11", k), 32'(run_en), 32'(VEC[k][3:0]));
        end
        @(negedge clk); idle();

        // R10, R8: flags 1010 on top of request 1000
        tc_hit = 4'hA;
        @(negedge clk); idle();
        rd(4'h8, v); chk("R10 R8 status read", 32'(v), 32'h8A);
        rd(4'h8, v); chk("R8 low cleared high kept", 32'(v), 32'h80);
        // R8: terminal count in the read cycle survives
        @(negedge clk); idle(); rd_en = 1; idx = 4'h8; tc_hit = 4'h1;
        #1 chk("R8 read with tc", 32'(rdata), 32'h80);
        @(negedge clk); idle();
        rd(4'h8, v); chk("R8 tc kept", 32'(v), 32'h81);
        // R3: soft request write clears the channel's count flag
        tc_hit = 4'h1; @(negedge clk); idle();
        wr(4'h9, 8'h00);
        rd(4'h8, v); chk("R3 clears tc bit", 32'(v), 32'h80);
        // R8 other index and no strobe
        rd(4'h9, v); chk("R8 other index", 32'(v), 32'h00);
        #1 chk("R8 no strobe", 32'(rdata), 32'h00);

        // R5 mode bytes
        wr(4'hB, 8'hE6);
        chk("R5 ch2 mode", mode_bus, 32'h00E60000);
        wr(4'hB, 8'h49);
        chk("R5 ch1 mode", mode_bus, 32'h00E64900);

        // R6 byte pointer clear pulse
        @(negedge clk); idle(); wr_en = 1; idx = 4'hC;
        #1 chk("R6 on C", 32'(ptr_clr), 32'h1);
        @(negedge clk); idle(); wr_en = 1; idx = 4'hE;
        #1 chk("R6 off E", 32'(ptr_clr), 32'h0);
        @(negedge clk); idle(); wr_en = 1; idx = 4'hD;
        #1 chk("R6 on D", 32'(ptr_clr), 32'h1);
        @(negedge clk); idle();
        #1 chk("R6 idle", 32'(ptr_clr), 32'h0);

        // R11 lowest eligible channel
        wr(4'hE, 8'h00);
        dreq_set = 4'hC; @(negedge clk); idle();
        chk("R11 run", 32'(run_en), 32'hC);
        chk("R11 pick", 32'({next_vld, next_ch}), 32'h6);
        dreq_set = 4'h2; @(negedge clk); idle();
        chk("R11 pick lower", 32'({next_vld, next_ch}), 32'h5);

        // R9 hold beats release in the same cycle
        dreq_set = 4'h1; dreq_clr = 4'h1; @(negedge clk); idle();
        chk("R9 set wins", 32'(run_en), 32'hF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule